// File: doc/BRIEF.md
# GPIO Pad Interrupt Controller

This block is a bank of general-purpose pads behind a small 32-bit register port. Each pad can be driven or sampled. Each pad can also be set up to raise an interrupt on a rising edge, a falling edge, either edge, or a steady high or low level. Pad inputs are first brought into the clock domain through two flops. The last synchronized sample is then compared with the one before it.

Events from ordinary pads are latched into status words of 32 pads each. Software reads a status word and acknowledges events by writing ones back to it. One combined interrupt line is high while any latched bit is set. A pad marked as direct skips the status words and drives its own interrupt output instead.

The register port is a plain strobe interface, with no back-pressure. A write completes on the clock edge where `wr_i` is high. A read returns its data on `rdata_o` one cycle after the edge where `rd_i` is high. Each pad has a 16-byte slot. The configuration word is at pad×16 and the value word is at pad×16+8. The status words start at byte 0x800.

Top module: `gpio_pad_irq_ctrl`

## Requirements
- R1: The configuration word at byte pad×16 stores write bits 27:24 and reads them back in place. Its other bits read as zero. All configuration resets to zero.
- R2: In the value word at pad×16+8, a write sets `pad_out_o[p]` from bit 0 and `pad_oe_o[p]` from bit 1. A read returns the synchronized pad level in bit 0, the output enable in bit 1 and the driven output level in bit 2. Both outputs reset to zero and change only on a write.
- R3: With bit 25 set and bit 24 clear, a rising edge on pad p sets bit p%32 of the status word at 0x800+4×(p/32). The bit becomes visible on the third clock edge after the input change.
- R4: With bit 26 set and bit 24 clear, a falling edge sets the status bit. With bits 25 and 26 both set, either edge sets it.
- R5: With bit 24 set, detection is level based: bit 25 selects active high and bit 26 selects active low. The status bit is set again on every cycle while the pad stays active, even directly after a clear.
- R6: A pad with bits 24, 25 and 26 all clear never sets its status bit and never drives its direct output.
- R7: A pad with bit 27 set drives `direct_irq_o[p]` one cycle after it detects an event: a one-cycle pulse for an edge, a steady high for a level. It never sets its status bit.
- R8: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R9: `irq_o` is high exactly while any status bit is set. It falls only after a write to the status area.
- R10: Read data appears the cycle after the read strobe. Unmapped offsets read as zero, including slot offsets other than 0 and 8, pads at or above NUM_PADS, and status words past the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address of the access |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe, one word per cycle |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_i` |
| pad_in_i | input | NUM_PADS | Asynchronous pad input levels |
| pad_out_o | output | NUM_PADS | Driven pad levels |
| pad_oe_o | output | NUM_PADS | Pad output enables |
| irq_o | output | 1 | Combined interrupt from latched status |
| direct_irq_o | output | NUM_PADS | Dedicated interrupts of direct pads |

## Verification
A wrong bit in a pad's synchronizer or history flop shows as a status bit or direct pulse that appears a cycle early, a cycle late, or without a matching edge. The bench samples these at the exact third edge after an input change, so such a fault surfaces within three cycles. A corrupted configuration or status bit shows at the next register read and through `irq_o` on the following edge. A status bit that is stuck or cannot be cleared keeps `irq_o` high after an acknowledge that should have lowered it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // Configuration field positions inside the 32-bit configuration word.
  localparam int CFG_LSB = 24;
  localparam int CFG_W   = 4;

  // Slot offsets inside a pad's 16-byte window.
  localparam logic [3:0] SLOT_CFG = 4'h0;
  localparam logic [3:0] SLOT_VAL = 4'h8;

  // Packed so that the MSB is write-data bit 27 and the LSB is bit 24.
  typedef struct packed {
    logic direct;   // bit 27: bypass shared status
    logic fall_en;  // bit 26: falling edge / active low
    logic rise_en;  // bit 25: rising edge / active high
    logic level;    // bit 24: level sensitive
  } pad_cfg_t;
endpackage

// File: rtl/gpio_pad_lane.sv
module gpio_pad_lane
  import gpio_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pad_raw_i,
  input  pad_cfg_t cfg_i,
  output logic     level_o,
  output logic     shared_ev_o,
  output logic     direct_o
);
  logic meta_q, sync_q, prev_q, direct_q;
  logic hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q   <= 1'b0;
      sync_q   <= 1'b0;
      prev_q   <= 1'b0;
      direct_q <= 1'b0;
    end else begin
      meta_q   <= pad_raw_i;
      sync_q   <= meta_q;
      prev_q   <= sync_q;
      direct_q <= cfg_i.direct & hit;
    end
  end

  always_comb begin
    if (cfg_i.level)
      hit = (cfg_i.rise_en & sync_q) | (cfg_i.fall_en & ~sync_q);
    else
      hit = (cfg_i.rise_en & sync_q & ~prev_q) | (cfg_i.fall_en & ~sync_q & prev_q);
  end

  assign level_o     = sync_q;
  assign shared_ev_o = hit & ~cfg_i.direct;
  assign direct_o    = direct_q;
endmodule

// File: rtl/gpio_status_bank.sv
module gpio_status_bank #(
  parameter int NUM_PADS = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PADS-1:0] set_i,
  input  logic [NUM_PADS-1:0] clr_i,
  output logic [NUM_PADS-1:0] status_o,
  output logic                any_o
);
  logic [NUM_PADS-1:0] status_q;

  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;
  assign any_o    = |status_q;
endmodule

// File: rtl/gpio_pad_irq_ctrl.sv
module gpio_pad_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PADS = 64,
  parameter int DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [11:0]         addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                wr_i,
  input  logic                rd_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PADS-1:0] pad_in_i,
  output logic [NUM_PADS-1:0] pad_out_o,
  output logic [NUM_PADS-1:0] pad_oe_o,
  output logic                irq_o,
  output logic [NUM_PADS-1:0] direct_irq_o
);
  localparam int NWORDS = (NUM_PADS + 31) / 32;
  localparam int STAT_W = NWORDS * 32;

  logic        is_stat;
  logic [6:0]  pad_fld;
  logic [3:0]  slot;
  logic [8:0]  word_fld;

  assign is_stat  = addr_i[11];
  assign pad_fld  = addr_i[10:4];
  assign slot     = addr_i[3:0];
  assign word_fld = addr_i[10:2];

  logic [CFG_W*NUM_PADS-1:0] cfg_flat;
  logic [NUM_PADS-1:0]       lvl_vec, ev_vec, clr_vec, status_q;
  logic [STAT_W-1:0]         stat_ext;
  logic                      any_set;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int WORD = p / 32;
    localparam int BIT  = p % 32;
    logic [CFG_W-1:0] cfg_q;
    logic             out_q, oe_q;
    logic             cfg_hit, val_hit;

    assign cfg_hit = !is_stat && (pad_fld == 7'(p)) && (slot == SLOT_CFG);
    assign val_hit = !is_stat && (pad_fld == 7'(p)) && (slot == SLOT_VAL);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q <= '0;
        out_q <= 1'b0;
        oe_q  <= 1'b0;
      end else if (wr_i) begin
        if (cfg_hit) cfg_q <= wdata_i[CFG_LSB +: CFG_W];
        if (val_hit) begin
          out_q <= wdata_i[0];
          oe_q  <= wdata_i[1];
        end
      end
    end

    assign cfg_flat[CFG_W*p +: CFG_W] = cfg_q;
    assign pad_out_o[p] = out_q;
    assign pad_oe_o[p]  = oe_q;
    assign clr_vec[p]   = wr_i && is_stat && (word_fld == 9'(WORD)) && wdata_i[BIT];

    gpio_pad_lane u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pad_raw_i   (pad_in_i[p]),
      .cfg_i       (pad_cfg_t'(cfg_q)),
      .level_o     (lvl_vec[p]),
      .shared_ev_o (ev_vec[p]),
      .direct_o    (direct_irq_o[p])
    );
  end

  gpio_status_bank #(.NUM_PADS(NUM_PADS)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (ev_vec),
    .clr_i    (clr_vec),
    .status_o (status_q),
    .any_o    (any_set)
  );

  assign irq_o    = any_set;
  assign stat_ext = STAT_W'(status_q);

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (!is_stat && pad_fld == 7'(p)) begin
        if (slot == SLOT_CFG) rd_mux[CFG_LSB +: CFG_W] = cfg_flat[CFG_W*p +: CFG_W];
        if (slot == SLOT_VAL) rd_mux[2:0] = {pad_out_o[p], pad_oe_o[p], lvl_vec[p]};
      end
    end
    for (int w = 0; w < NWORDS; w++) begin
      if (is_stat && word_fld == 9'(w)) rd_mux = stat_ext[32*w +: 32];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/gpio_pad_irq_ctrl_chk.sv
module gpio_pad_irq_ctrl_chk #(
  parameter int NUM_PADS = 64
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_i,
  input logic [11:0]           addr_i,
  input logic                  irq_o,
  input logic [NUM_PADS-1:0]   direct_irq_o,
  input logic [NUM_PADS-1:0]   pad_out_o,
  input logic [NUM_PADS-1:0]   status,
  input logic [4*NUM_PADS-1:0] cfg_flat
);
  logic [NUM_PADS-1:0] dir_v, any_v;
  always_comb begin
    for (int p = 0; p < NUM_PADS; p++) begin
      dir_v[p] = cfg_flat[4*p+3];
      any_v[p] = |cfg_flat[4*p +: 3];
    end
  end

  // R7
  direct_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (direct_irq_o & ~$past(dir_v)) == '0);

  // R7
  direct_no_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status & ~$past(status) & $past(dir_v)) == '0);

  // R6
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status & ~$past(status) & ~$past(any_v)) == '0);

  // R9
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_i && addr_i[11]));

  // R2
  pad_out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_i) |-> $stable(pad_out_o));
endmodule

bind gpio_pad_irq_ctrl gpio_pad_irq_ctrl_chk #(.NUM_PADS(NUM_PADS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_i         (wr_i),
  .addr_i       (addr_i),
  .irq_o        (irq_o),
  .direct_irq_o (direct_irq_o),
  .pad_out_o    (pad_out_o),
  .status       (status_q),
  .cfg_flat     (cfg_flat)
);

// File: tb/sim_gpio_pad_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_pad_irq_ctrl;
  localparam int NP = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [31:0]   rdata;
  logic [NP-1:0] pads = '0;
  logic [NP-1:0] pout, poe, dirq;
  logic          irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_pad_irq_ctrl #(.NUM_PADS(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .pad_in_i(pads),
    .pad_out_o(pout), .pad_oe_o(poe), .irq_o(irq), .direct_irq_o(dirq)
  );

  function automatic logic [11:0] cfg_a(int p);  return 12'(p * 16);     endfunction
  function automatic logic [11:0] val_a(int p);  return 12'(p * 16 + 8); endfunction
  function automatic logic [11:0] stat_a(int p); return 12'(12'h800 + 4 * (p / 32)); endfunction
  function automatic logic [31:0] sbit(int p);   return 32'h1 << (p % 32); endfunction
  function automatic logic [31:0] exp_cfg(logic [31:0] w); return w & 32'h0F00_0000; endfunction
  function automatic logic [31:0] exp_val(logic lvl, logic [31:0] w);
    return {29'b0, w[0], w[1], lvl};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [11:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic clear_all();
    wr_reg(12'h800, 32'hFFFF_FFFF);
    wr_reg(12'h804, 32'hFFFF_FFFF);
  endtask

  task automatic settle(); repeat (4) @(negedge clk); endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, w;
    void'($urandom(32'd20240601));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R9: reset state
    chk(irq == 1'b0 && dirq == '0, "R9 reset irq", {31'b0, irq}, 0);
    chk(pout == '0 && poe == '0, "R2 reset pads", pout[31:0], 0);
    rd_reg(cfg_a(10), d);
    chk(d == 32'h0, "R1 reset cfg", d, 0);

    // R1 R2: random config and value accesses against bench functions
    for (int i = 0; i < 40; i++) begin
      int p = int'($urandom % NP);
      w = $urandom;
      pads[p] = w[5];
      wr_reg(cfg_a(p), w);
      rd_reg(cfg_a(p), d);
      chk(d == exp_cfg(w), "R1 cfg readback", d, exp_cfg(w));
      w = $urandom;
      wr_reg(val_a(p), w);
      chk(pout[p] == w[0] && poe[p] == w[1], "R2 pad drive", {30'b0, poe[p], pout[p]}, {30'b0, w[1], w[0]});
      settle();
      rd_reg(val_a(p), d);
      chk(d == exp_val(pads[p], w), "R2 value readback", d, exp_val(pads[p], w));
    end
    for (int p = 0; p < NP; p++) wr_reg(cfg_a(p), 32'h0);
    pads = '0;
    settle();
    clear_all();
    chk(irq == 1'b0, "R9 idle after cleanup", {31'b0, irq}, 0);

    // R10: unmapped offsets read zero
    rd_reg(12'h808, d);            chk(d == 0, "R10 status past end", d, 0);
    rd_reg(cfg_a(3) + 12'd4, d);   chk(d == 0, "R10 slot gap", d, 0);
    rd_reg(cfg_a(100), d);         chk(d == 0, "R10 pad beyond bank", d, 0);

    // R3: rising edge, exact latency of three edges
    wr_reg(cfg_a(20), 32'h0200_0000);
    @(negedge clk); pads[20] = 1'b1;
    @(negedge clk); chk(irq == 1'b0, "R3 edge1", {31'b0, irq}, 0);
    @(negedge clk); chk(irq == 1'b0, "R3 edge2", {31'b0, irq}, 0);
    @(negedge clk); chk(irq == 1'b1, "R3 edge3", {31'b0, irq}, 1);
    rd_reg(stat_a(20), d);
    chk(d == sbit(20), "R3 status word", d, sbit(20));
    // R8: writing zeros and other ones leaves the bit set
    wr_reg(stat_a(20), ~sbit(20));
    rd_reg(stat_a(20), d);
    chk(d == sbit(20), "R8 zero write keeps", d, sbit(20));
    wr_reg(stat_a(20), sbit(20));
    @(negedge clk);
    chk(irq == 1'b0, "R8 clear lowers irq R9", {31'b0, irq}, 0);
    pads[20] = 1'b0; settle();
    rd_reg(stat_a(20), d);
    chk(d == 0, "R3 falling ignored", d, 0);

    // R4: falling edge on pad 40 (word 1, bit 8)
    wr_reg(cfg_a(40), 32'h0400_0000);
    pads[40] = 1'b1; settle();
    rd_reg(stat_a(40), d); chk(d == 0, "R4 rise ignored", d, 0);
    pads[40] = 1'b0; settle();
    rd_reg(stat_a(40), d); chk(d == sbit(40), "R4 fall sets", d, sbit(40));
    clear_all();

    // R4: both edges on pad 3
    wr_reg(cfg_a(3), 32'h0600_0000);
    pads[3] = 1'b1; settle();
    rd_reg(stat_a(3), d); chk(d == sbit(3), "R4 both rise", d, sbit(3));
    clear_all();
    pads[3] = 1'b0; settle();
    rd_reg(stat_a(3), d); chk(d == sbit(3), "R4 both fall", d, sbit(3));
    clear_all();

    // R5 R8: active-high level re-sets through a clear
    wr_reg(cfg_a(7), 32'h0300_0000);
    pads[7] = 1'b1; settle();
    rd_reg(stat_a(7), d); chk(d == sbit(7), "R5 level high", d, sbit(7));
    wr_reg(stat_a(7), sbit(7));
    rd_reg(stat_a(7), d); chk(d == sbit(7), "R5 R8 set beats clear", d, sbit(7));
    pads[7] = 1'b0; settle(); clear_all();
    rd_reg(stat_a(7), d); chk(d == 0, "R5 inactive clears", d, 0);

    // R5: active-low level on pad 9
    wr_reg(cfg_a(9), 32'h0500_0000);
    settle();
    rd_reg(stat_a(9), d); chk(d == sbit(9), "R5 level low", d, sbit(9));
    wr_reg(cfg_a(9), 32'h0); clear_all();
    rd_reg(stat_a(9), d); chk(d == 0, "R6 masked after clear", d, 0);

    // R6: masked pad toggling
    pads[30] = 1'b1; settle(); pads[30] = 1'b0; settle();
    rd_reg(stat_a(30), d);
    chk(d == 0 && irq == 1'b0 && dirq == '0, "R6 masked quiet", d, 0);

    // R7: direct pad pulses its own line, status untouched
    wr_reg(cfg_a(12), 32'h0A00_0000);
    @(negedge clk); pads[12] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(dirq[12] == 1'b0, "R7 before pulse", {31'b0, dirq[12]}, 0);
    @(negedge clk);
    chk(dirq == (64'h1 << 12), "R7 pulse", dirq[31:0], 32'h1000);
    @(negedge clk);
    chk(dirq[12] == 1'b0, "R7 pulse ends", {31'b0, dirq[12]}, 0);
    rd_reg(stat_a(12), d);
    chk(d == 0 && irq == 1'b0, "R7 no status", d, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule